// File: doc/BRIEF.md
# Six-Channel Sample Frame Serializer

This block turns sets of six 12-bit channel samples into fixed 14-byte binary frames and sends them on an asynchronous serial transmit line in the 8N1 format. A producer presents a whole sample set on a valid/ready handshake. The block captures the set at acceptance and starts the frame. A receiver can find each frame by searching for the two-byte sync pattern at its head.

A serial receiver on the same block takes single-byte commands from the host. One command toggles a pause state. While paused, sample sets are still accepted but are thrown away, so the producer never stalls. Another command toggles a doubling of every sample before it is framed. A command that arrives during a frame is held and applied only when that frame has finished. A second command that arrives while one is still held is lost, and an overrun flag is raised. All command reception then stops until the flag is cleared.

One enable input, `baud_tick`, paces both directions. It runs at `OVS` times the bit rate, so one bit lasts `OVS` enabled cycles.

Top module: `scope_frame_tx`

## Requirements
- R1: After reset `tx_o` is 1, `paused_o`, `scale2_o` and `ovr_o` are 0, and `smp_ready` is 1.
- R2: A frame has 14 bytes. Byte 0 is 0x55 and byte 1 is 0xAA. These are followed by six 16-bit fields for channel 1 to channel 6, each sent high byte first. Channel k is taken from `smp_data[12k-1:12k-12]` and zero-extended.
- R3: Every byte is sent as a start bit of 0, then eight data bits LSB first, then a stop bit of 1. Each bit lasts `OVS` enabled ticks, and the line is 1 when idle.
- R4: `smp_ready` is 0 while a frame is being sent. The sample set is captured in the acceptance cycle, so later changes on `smp_data` do not alter that frame.
- R5: If a sample set is waiting when a frame ends, the start bit of the next frame follows the last stop bit within a few clock cycles, with no idle bit time inserted.
- R6: Receiving 0x53 ('S') toggles `scale2_o`. While it is 1, each field carries twice the raw sample, so 0xFFF is sent as 0x1FFE.
- R7: Receiving 0x50 ('P') toggles `paused_o`. While it is 1, sample sets are still accepted, no frame is sent, and `tx_o` stays 1.
- R8: A command that arrives during a frame does not change `paused_o` or `scale2_o` until that frame has completed, and the frame is always sent whole.
- R9: A byte that completes while an earlier command is still held sets `ovr_o` and is dropped. While `ovr_o` is 1, every received byte is dropped. A one-cycle pulse on `ovr_clr` clears the flag and re-enables reception.
- R10: Any received byte other than 0x50 and 0x53 changes neither `paused_o` nor `scale2_o`, and does not set `ovr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Enable at OVS times the bit rate |
| smp_valid | input | 1 | Sample set offered |
| smp_ready | output | 1 | Sample set can be accepted this cycle |
| smp_data | input | NCH*SW (72) | Six packed samples, channel 1 in the low bits |
| rx_i | input | 1 | Serial command input line |
| ovr_clr | input | 1 | Clears the overrun flag |
| tx_o | output | 1 | Serial frame output line |
| paused_o | output | 1 | Pause state |
| scale2_o | output | 1 | Doubling state |
| ovr_o | output | 1 | Command overrun flag |

## Verification
The bench sweeps frame contents over all-zero sets, all-ones sets, walking-bit sets, alternating-bit sets and arithmetic sequences. Each is sent at scale 1 and again at scale 2. These patterns separate a swapped byte order, a misplaced channel slice, a missing carry into the ninth bit of a doubled value, and bit-order faults on the line. Command bytes are sent both while the block is idle and in the middle of a frame. This separates an immediate status change from one held to the frame boundary. Two commands inside one frame, a command sent with the overrun flag set, and foreign byte values exercise the drop paths. A producer that holds the next set ready exposes any delay inserted between frames.

// File: rtl/sft_pkg.sv
package sft_pkg;
   localparam logic [7:0] SYNC_FIRST  = 8'h55;
   localparam logic [7:0] SYNC_SECOND = 8'hAA;
   localparam logic [7:0] CMD_PAUSE   = 8'h50;
   localparam logic [7:0] CMD_SCALE   = 8'h53;
   localparam int FIELD_W = 16;

   typedef enum logic [1:0] {FR_IDLE, FR_LOAD, FR_WAIT} fr_state_e;
   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/sft_uart_tx.sv
module sft_uart_tx #(
   parameter int OVS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       load_i,
   input  logic [7:0] data_i,
   output logic       busy_o,
   output logic       done_o,
   output logic       tx_o
);
   localparam int CW = (OVS > 2) ? $clog2(OVS) : 1;

   logic [9:0]    shreg;
   logic [3:0]    bitcnt;
   logic [CW-1:0] tcnt;
   logic          busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg  <= '1;
         bitcnt <= '0;
         tcnt   <= '0;
         busy_q <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!busy_q) begin
            if (load_i) begin
               shreg  <= {1'b1, data_i, 1'b0};
               busy_q <= 1'b1;
               bitcnt <= '0;
               tcnt   <= '0;
            end
         end else if (tick_i) begin
            if (tcnt == CW'(OVS - 1)) begin
               tcnt  <= '0;
               shreg <= {1'b1, shreg[9:1]};
               if (bitcnt == 4'd9) begin
                  busy_q <= 1'b0;
                  done_o <= 1'b1;
               end else begin
                  bitcnt <= bitcnt + 4'd1;
               end
            end else begin
               tcnt <= tcnt + CW'(1);
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign tx_o   = busy_q ? shreg[0] : 1'b1;

   // R3: each byte opens with a low start bit and closes with a high stop bit
   a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> !tx_o);
   a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(tx_o));
endmodule

// File: rtl/sft_uart_rx.sv
module sft_uart_rx
   import sft_pkg::*;
#(
   parameter int OVS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       rx_i,
   output logic       vld_o,
   output logic [7:0] byte_o
);
   localparam int CW   = (OVS > 2) ? $clog2(OVS) : 1;
   localparam int HALF = (OVS / 2 > 0) ? OVS / 2 : 1;

   logic          s1, rxs;
   rx_state_e     st;
   logic [CW-1:0] cnt;
   logic [2:0]    bitn;
   logic [7:0]    sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1  <= 1'b1;
         rxs <= 1'b1;
      end else begin
         s1  <= rx_i;
         rxs <= s1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= RX_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         sh    <= '0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= 1'b0;
         if (tick_i) begin
            case (st)
               RX_IDLE: begin
                  if (!rxs) begin
                     st  <= RX_START;
                     cnt <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == CW'(HALF - 1)) begin
                     cnt  <= '0;
                     bitn <= '0;
                     st   <= rxs ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               RX_DATA: begin
                  if (cnt == CW'(OVS - 1)) begin
                     cnt <= '0;
                     sh  <= {rxs, sh[7:1]};
                     if (bitn == 3'd7) st <= RX_STOP;
                     else              bitn <= bitn + 3'd1;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
               default: begin
                  if (cnt == CW'(OVS - 1)) begin
                     cnt   <= '0;
                     st    <= RX_IDLE;
                     vld_o <= rxs;
                  end else begin
                     cnt <= cnt + CW'(1);
                  end
               end
            endcase
         end
      end
   end

   assign byte_o = sh;
endmodule

// File: rtl/sft_cmd_ctl.sv
module sft_cmd_ctl
   import sft_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_vld_i,
   input  logic [7:0] rx_byte_i,
   input  logic       consume_i,
   input  logic       ovr_clr_i,
   output logic       pending_o,
   output logic       paused_o,
   output logic       scale_o,
   output logic       ovr_o
);
   logic       pend_q, paused_q, scale_q, ovr_q;
   logic [7:0] cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q   <= 1'b0;
         paused_q <= 1'b0;
         scale_q  <= 1'b0;
         ovr_q    <= 1'b0;
         cmd_q    <= '0;
      end else begin
         if (pend_q && consume_i) begin
            pend_q <= 1'b0;
            if (cmd_q == CMD_PAUSE) paused_q <= !paused_q;
            if (cmd_q == CMD_SCALE) scale_q  <= !scale_q;
         end
         if (rx_vld_i && !ovr_q) begin
            if (pend_q && !consume_i) begin
               ovr_q <= 1'b1;
            end else begin
               cmd_q  <= rx_byte_i;
               pend_q <= 1'b1;
            end
         end
         if (ovr_clr_i) ovr_q <= 1'b0;
      end
   end

   assign pending_o = pend_q;
   assign paused_o  = paused_q;
   assign scale_o   = scale_q;
   assign ovr_o     = ovr_q;

   // R9: a byte landing on a held command raises the flag
   a_r9_ovr_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_vld_i && pend_q && !consume_i && !ovr_clr_i) |=> ovr_q);
   // R9: with the flag up nothing new is held
   a_r9_drop_while_ovr: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_vld_i && ovr_q && !pend_q) |=> !pend_q);
   // R10: foreign bytes leave both status bits alone
   a_r10_other_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && consume_i && cmd_q != CMD_PAUSE && cmd_q != CMD_SCALE)
      |=> ($stable(paused_q) && $stable(scale_q)));
endmodule

// File: rtl/sft_framer.sv
module sft_framer
   import sft_pkg::*;
#(
   parameter int NCH = 6,
   parameter int SW  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid_i,
   input  logic [NCH*SW-1:0] smp_data_i,
   input  logic              cmd_pending_i,
   input  logic              paused_i,
   input  logic              scale_i,
   input  logic              tx_done_i,
   output logic              smp_ready_o,
   output logic              idle_o,
   output logic              tx_load_o,
   output logic [7:0]        tx_byte_o
);
   localparam int NB   = 2 + 2 * NCH;
   localparam int FV   = NB * 8;
   localparam int IW   = $clog2(NB);
   localparam int MAXV = 2 * ((1 << SW) - 1);

   fr_state_e     st;
   logic [IW-1:0] idx;
   logic [FV-1:0] fv_q, fv_next;
   logic          accept, accept_q;

   assign fv_next[FV-1 -: 16] = {SYNC_FIRST, SYNC_SECOND};

   for (genvar c = 0; c < NCH; c++) begin : g_field
      localparam int POS = (NB - 4 - 2 * c) * 8;
      logic [SW-1:0] raw;
      assign raw = smp_data_i[c*SW +: SW];
      if (FIELD_W - SW > 1) begin : g_pad
         assign fv_next[POS +: FIELD_W] = scale_i ?
            {{(FIELD_W - SW - 1){1'b0}}, raw, 1'b0} :
            {{(FIELD_W - SW){1'b0}}, raw};
      end else begin : g_nopad
         assign fv_next[POS +: FIELD_W] = scale_i ? {raw, 1'b0} : {1'b0, raw};
      end

      // R6: a captured field never exceeds twice the largest raw sample
      a_r6_field_bound: assert property (@(posedge clk) disable iff (!rst_n)
         accept_q |-> (32'(fv_q[POS +: FIELD_W]) <= MAXV));
   end

   assign smp_ready_o = (st == FR_IDLE) && !cmd_pending_i;
   assign accept      = smp_valid_i && smp_ready_o;
   assign idle_o      = (st == FR_IDLE);
   assign tx_load_o   = (st == FR_LOAD);
   assign tx_byte_o   = fv_q[FV-1 -: 8];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= FR_IDLE;
         idx      <= '0;
         fv_q     <= '0;
         accept_q <= 1'b0;
      end else begin
         accept_q <= 1'b0;
         case (st)
            FR_IDLE: begin
               if (accept && !paused_i) begin
                  fv_q     <= fv_next;
                  idx      <= '0;
                  st       <= FR_LOAD;
                  accept_q <= 1'b1;
               end
            end
            FR_LOAD: st <= FR_WAIT;
            default: begin
               if (tx_done_i) begin
                  fv_q <= fv_q << 8;
                  if (idx == IW'(NB - 1)) begin
                     st <= FR_IDLE;
                  end else begin
                     idx <= idx + IW'(1);
                     st  <= FR_LOAD;
                  end
               end
            end
         endcase
      end
   end

   // R2: every frame opens with the first sync byte
   a_r2_sync_first: assert property (@(posedge clk) disable iff (!rst_n)
      (st == FR_LOAD && idx == '0) |-> (tx_byte_o == SYNC_FIRST));
endmodule

// File: rtl/scope_frame_tx.sv
module scope_frame_tx #(
   parameter int NCH = 6,
   parameter int SW  = 12,
   parameter int OVS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              smp_valid,
   output logic              smp_ready,
   input  logic [NCH*SW-1:0] smp_data,
   input  logic              rx_i,
   input  logic              ovr_clr,
   output logic              tx_o,
   output logic              paused_o,
   output logic              scale2_o,
   output logic              ovr_o
);
   if (NCH < 1 || SW < 1 || SW > 15 || OVS < 2) begin : g_bad_cfg
      $error("scope_frame_tx: need NCH>=1, 1<=SW<=15, OVS>=2");
   end

   logic       rx_vld;
   logic [7:0] rx_byte;
   logic       pending, fr_idle;
   logic       tx_load, tx_busy, tx_done;
   logic [7:0] tx_byte;

   sft_uart_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick_i(baud_tick), .rx_i(rx_i),
      .vld_o(rx_vld), .byte_o(rx_byte)
   );

   sft_cmd_ctl u_cmd (
      .clk(clk), .rst_n(rst_n), .rx_vld_i(rx_vld), .rx_byte_i(rx_byte),
      .consume_i(fr_idle), .ovr_clr_i(ovr_clr), .pending_o(pending),
      .paused_o(paused_o), .scale_o(scale2_o), .ovr_o(ovr_o)
   );

   sft_framer #(.NCH(NCH), .SW(SW)) u_fr (
      .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
      .cmd_pending_i(pending), .paused_i(paused_o), .scale_i(scale2_o),
      .tx_done_i(tx_done), .smp_ready_o(smp_ready), .idle_o(fr_idle),
      .tx_load_o(tx_load), .tx_byte_o(tx_byte)
   );

   sft_uart_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick_i(baud_tick), .load_i(tx_load),
      .data_i(tx_byte), .busy_o(tx_busy), .done_o(tx_done), .tx_o(tx_o)
   );

   // R8: status bits move only while no frame is in flight
   a_r8_status_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(paused_o) || !$stable(scale2_o)) |-> $past(fr_idle));
   // R4: no acceptance while the line is busy
   a_r4_ready_off_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> !smp_ready);
endmodule

// File: tb/tb_scope_frame_tx.sv
`timescale 1ns/1ps
module tb_scope_frame_tx;
   localparam int NCH = 6;
   localparam int SW  = 12;
   localparam int OVS = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              baud_tick = 1'b1;
   logic              smp_valid = 1'b0;
   logic              smp_ready;
   logic [NCH*SW-1:0] smp_data = '0;
   logic              rx_i = 1'b1;
   logic              ovr_clr = 1'b0;
   logic              tx_o, paused_o, scale2_o, ovr_o;

   int ntests = 0;
   int nfail  = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   scope_frame_tx #(.NCH(NCH), .SW(SW), .OVS(OVS)) dut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .smp_valid(smp_valid),
      .smp_ready(smp_ready), .smp_data(smp_data), .rx_i(rx_i), .ovr_clr(ovr_clr),
      .tx_o(tx_o), .paused_o(paused_o), .scale2_o(scale2_o), .ovr_o(ovr_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      ntests++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int pv(input int p, input int c);
      case (p)
         0: return 0;
         1: return 4095;
         2: return 1 << (2 * c);
         3: return 12'hAAA ^ (c * 12'h111);
         default: return (p * 1237 + c * 611 + 1) % 4096;
      endcase
   endfunction

   task automatic get_byte(output logic [7:0] b, output int waited);
      int t = 0;
      b = '0;
      @(negedge clk);
      while (tx_o !== 1'b0 && t < 3000) begin
         @(negedge clk);
         t++;
      end
      waited = t;
      if (t >= 3000) chk(0, "R3", "start bit timeout", t, 0);
      repeat (OVS / 2) @(negedge clk);
      if (tx_o !== 1'b0) chk(0, "R3", "start bit level", tx_o, 0);
      for (int i = 0; i < 8; i++) begin
         repeat (OVS) @(negedge clk);
         b[i] = tx_o;
      end
      repeat (OVS) @(negedge clk);
      if (tx_o !== 1'b1) chk(0, "R3", "stop bit level", tx_o, 1);
   endtask

   task automatic get_frame(output logic [7:0] fr [0:13], output int first_wait);
      int w;
      for (int k = 0; k < 14; k++) begin
         get_byte(fr[k], w);
         if (k == 0) first_wait = w;
      end
   endtask

   task automatic chk_frame(input logic [7:0] fr [0:13], input int p,
                            input bit dbl, input string req);
      int f;
      chk(fr[0] == 8'h55, req, "sync byte 0", fr[0], 8'h55);
      chk(fr[1] == 8'hAA, req, "sync byte 1", fr[1], 8'hAA);
      for (int c = 0; c < 6; c++) begin
         f = dbl ? 2 * pv(p, c) : pv(p, c);
         chk(fr[2 + 2 * c] == 8'(f >> 8), req, $sformatf("ch%0d high", c + 1),
             fr[2 + 2 * c], f >> 8);
         chk(fr[3 + 2 * c] == 8'(f & 255), req, $sformatf("ch%0d low", c + 1),
             fr[3 + 2 * c], f & 255);
      end
   endtask

   task automatic push_set(input int p, output bit ok);
      int t = 0;
      @(negedge clk);
      for (int c = 0; c < 6; c++) smp_data[c*SW +: SW] = SW'(pv(p, c));
      smp_valid = 1'b1;
      while (smp_ready !== 1'b1 && t < 3000) begin
         @(negedge clk);
         t++;
      end
      ok = (t < 3000);
      @(posedge clk);
      @(negedge clk);
      smp_valid = 1'b0;
      smp_data  = {3{24'hC3A55A}};
   endtask

   task automatic send_rx(input logic [7:0] b);
      @(negedge clk);
      rx_i = 1'b0;
      repeat (OVS) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx_i = b[i];
         repeat (OVS) @(negedge clk);
      end
      rx_i = 1'b1;
      repeat (OVS) @(negedge clk);
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         nfail++;
         ntests++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] fr [0:13];
      logic [7:0] fr2 [0:13];
      int  w, w2;
      bit  ok;
      bit  quiet;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(tx_o === 1'b1, "R1", "tx idle", tx_o, 1);
      chk(paused_o === 1'b0, "R1", "paused", paused_o, 0);
      chk(scale2_o === 1'b0, "R1", "scale", scale2_o, 0);
      chk(ovr_o === 1'b0, "R1", "overrun", ovr_o, 0);
      chk(smp_ready === 1'b1, "R1", "ready", smp_ready, 1);

      // R2 R3 R4: pattern sweep at scale 1; data is scrambled after capture
      for (int p = 0; p < 8; p++) begin
         push_set(p, ok);
         chk(ok, "R4", "accept", ok, 1);
         fork
            get_frame(fr, w);
            begin
               repeat (3) @(negedge clk);
               chk(smp_ready === 1'b0, "R4", "ready low in flight", smp_ready, 0);
            end
         join
         chk_frame(fr, p, 1'b0, "R2");
         settle();
      end

      // R6: scale toggle while idle, then sweep doubled values
      send_rx(8'h53);
      settle();
      chk(scale2_o === 1'b1, "R6", "scale on", scale2_o, 1);
      for (int p = 0; p < 5; p++) begin
         push_set(p, ok);
         get_frame(fr, w);
         chk_frame(fr, p, 1'b1, "R6");
         settle();
      end
      send_rx(8'h53);
      settle();
      chk(scale2_o === 1'b0, "R6", "scale off", scale2_o, 0);

      // R10: foreign bytes
      send_rx(8'h58);
      settle();
      send_rx(8'h00);
      settle();
      send_rx(8'hFF);
      settle();
      chk(paused_o === 1'b0, "R10", "paused untouched", paused_o, 0);
      chk(scale2_o === 1'b0, "R10", "scale untouched", scale2_o, 0);
      chk(ovr_o === 1'b0, "R10", "no overrun", ovr_o, 0);

      // R7: paused sets are accepted and discarded
      send_rx(8'h50);
      settle();
      chk(paused_o === 1'b1, "R7", "paused on", paused_o, 1);
      push_set(4, ok);
      chk(ok, "R7", "accept while paused", ok, 1);
      quiet = 1'b1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (tx_o !== 1'b1) quiet = 1'b0;
      end
      chk(quiet, "R7", "line quiet while paused", quiet, 1);
      send_rx(8'h50);
      settle();
      chk(paused_o === 1'b0, "R7", "paused off", paused_o, 0);
      quiet = 1'b1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (tx_o !== 1'b1) quiet = 1'b0;
      end
      chk(quiet, "R7", "discarded set not sent", quiet, 1);

      // R8: pause command mid-frame waits for the frame end
      push_set(5, ok);
      fork
         get_frame(fr, w);
         begin
            repeat (20) @(negedge clk);
            send_rx(8'h50);
            repeat (10) @(negedge clk);
            chk(paused_o === 1'b0, "R8", "paused held mid-frame", paused_o, 0);
         end
      join
      chk_frame(fr, 5, 1'b0, "R8");
      settle();
      chk(paused_o === 1'b1, "R8", "paused after frame", paused_o, 1);
      send_rx(8'h50);
      settle();
      chk(paused_o === 1'b0, "R8", "resume", paused_o, 0);

      // R5: back-to-back frames with the next set waiting
      push_set(6, ok);
      fork
         begin
            get_frame(fr, w);
            get_frame(fr2, w2);
         end
         push_set(7, ok);
      join
      chk_frame(fr, 6, 1'b0, "R5");
      chk_frame(fr2, 7, 1'b0, "R5");
      chk(w2 <= OVS / 2 + 4, "R5", "gap between frames", w2, OVS / 2 + 4);
      settle();

      // R9: two commands inside one frame
      push_set(2, ok);
      fork
         get_frame(fr, w);
         begin
            repeat (10) @(negedge clk);
            send_rx(8'h53);
            send_rx(8'h50);
            repeat (4) @(negedge clk);
            chk(ovr_o === 1'b1, "R9", "overrun raised", ovr_o, 1);
         end
      join
      chk_frame(fr, 2, 1'b0, "R9");
      settle();
      chk(scale2_o === 1'b1, "R9", "first command applied", scale2_o, 1);
      chk(paused_o === 1'b0, "R9", "second command dropped", paused_o, 0);
      send_rx(8'h50);
      settle();
      chk(paused_o === 1'b0, "R9", "dropped while flagged", paused_o, 0);
      @(negedge clk);
      ovr_clr = 1'b1;
      @(negedge clk);
      ovr_clr = 1'b0;
      chk(ovr_o === 1'b0, "R9", "flag cleared", ovr_o, 0);
      send_rx(8'h50);
      settle();
      chk(paused_o === 1'b1, "R9", "reception restored", paused_o, 1);
      send_rx(8'h50);
      settle();
      send_rx(8'h53);
      settle();
      chk(paused_o === 1'b0 && scale2_o === 1'b0, "R9", "status restored",
          {paused_o, scale2_o}, 0);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end
endmodule